// File: doc/BRIEF.md
# Mailbox Interrupt Flag and Mask Unit

This unit keeps the per-mailbox event flags and interrupt masks of a 32-mailbox message controller. The controller core sends one-cycle event pulses, each a 32-bit vector with one bit per mailbox. A pulse for a received data frame, a received remote frame or an overwritten unread message sets the matching flag. A pulse for a finished or aborted transmission closes out that mailbox's transmit request and sets an acknowledge flag.

Software reaches every register as 16-bit halves on a plain register bus. The write is a single-cycle strobe. The read path is combinational from the address. A per-mailbox direction bit marks each mailbox as receive or transmit. Together with the mask, it decides which mailboxes drive the four registered interrupt request lines. The mask only ever gates those lines. The flags and the transmit bookkeeping behave the same whether a mailbox is masked or not.

Top module: `mbx_irq_unit`

Register word addresses are `2*index + half`. `half` = 0 selects mailboxes 15..0 and `half` = 1 selects mailboxes 31..16. Bit k of a half covers mailbox `16*half + k`.

| Index | Register | Access |
|---|---|---|
| 0 | data-received flags | write 1 clears |
| 1 | remote-received flags | write 1 clears |
| 2 | overwrite flags | write 1 clears |
| 3 | transmit-ack flags | write 1 clears |
| 4 | abort-ack flags | write 1 clears |
| 5 | interrupt mask | read/write; 1 = masked |
| 6 | direction | read/write; 1 = transmit, 0 = receive |
| 7 | transmit-pending | write 1 sets |
| 8 | cancel-request | write 1 sets |

## Requirements
- R1: While `rst` is high and after it falls, all flags, direction, transmit-pending and cancel-request bits read 0. Every mask bit reads 1, so addresses 10 and 11 read 0xFFFF. All four interrupt lines are low.
- R2: An event pulse on bit m of `evRxData`, `evRxRemote`, `evOverwrite`, `evTxDone` or `evTxAbort` sets the flag of mailbox m in register index 0, 1, 2, 3 or 4 respectively. The flag is readable in the cycle after the pulse's edge, at bit `m mod 16` of address `2*index + m/16`.
- R3: Writing a 1 bit to a flag register clears that flag. Writing a 0 bit leaves it unchanged.
- R4: When an event and a write-1-to-clear hit the same flag bit in the same cycle, the flag ends up set.
- R5: The mask (addresses 10/11) and direction (addresses 12/13) halves read back the last value written to them. Writing one half does not touch the other half.
- R6: `irqRxData`, `irqRemote` and `irqOverrun` are the OR over receive mailboxes (direction 0) of flag index 0, 1 and 2 respectively, ANDed with the inverted mask bit. Each line is registered, so it follows the flags and masks one cycle later.
- R7: `irqEmpty` is the OR over transmit mailboxes (direction 1) of (transmit-ack OR abort-ack) AND NOT mask. It is registered one cycle like R6.
- R8: The mask never changes a flag. Masked mailboxes still get their flags set. Clearing a mask bit while its flag is set raises the line one cycle after the write. Setting the mask drops the line one cycle after the write, and the flag stays set.
- R9: A finished transmission (`evTxDone`) or an abort (`evTxAbort`) on mailbox m clears transmit-pending (index 7) and cancel-request (index 8) bit m, whatever the mask. Writing 1 to those registers sets bits. If a write-1 and a finish hit the same bit in the same cycle, the bit ends up set.
- R10: Addresses 18 to 31 read 0, and writes to them change no register.
- R11: A receive-type flag on a transmit mailbox never raises a receive interrupt line. A transmit-ack or abort-ack flag on a receive mailbox never raises `irqEmpty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` (combinational) |
| evRxData | input | 32 | Data frame received, per mailbox |
| evRxRemote | input | 32 | Remote frame received, per mailbox |
| evOverwrite | input | 32 | Unread message overwritten, per mailbox |
| evTxDone | input | 32 | Transmission finished, per mailbox |
| evTxAbort | input | 32 | Transmission aborted, per mailbox |
| irqRxData | output | 1 | Data-received interrupt request |
| irqRemote | output | 1 | Remote-frame interrupt request |
| irqOverrun | output | 1 | Overwrite interrupt request |
| irqEmpty | output | 1 | Mailbox-empty interrupt request |

## Verification
The directed patterns check separate questions:
- Events on masked mailboxes show that flags are recorded while the lines stay quiet.
- Unmasking and then remasking one mailbox checks the gate against the one-cycle register delay.
- An event that lands in the same cycle as a clear, or a finish that lands in the same cycle as a new request, shows which side wins.
- Events on a mailbox whose direction points the other way tell the direction gating apart from the mask gating.

A long stretch of random events and writes, spread over used and unused addresses, is then compared cycle by cycle against a behavioural model. This catches wrong half selection and wrong bit-to-mailbox mapping.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int MBX_COUNT = 32;
  localparam int REG_W     = 16;
  localparam int HALVES    = MBX_COUNT / REG_W;
  localparam int HALF_W    = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam int NREG      = 9;
  localparam int NFLAG     = 5;
  localparam int SEL_W     = $clog2(NREG);
  localparam int ADDR_W    = SEL_W + HALF_W;

  // register indices; the five flag registers come first
  localparam int IDX_RX     = 0;
  localparam int IDX_RMT    = 1;
  localparam int IDX_OVR    = 2;
  localparam int IDX_TXACK  = 3;
  localparam int IDX_ABACK  = 4;
  localparam int IDX_MASK   = 5;
  localparam int IDX_DIR    = 6;
  localparam int IDX_TXPEND = 7;
  localparam int IDX_CANCEL = 8;

  typedef struct packed {
    logic [NREG-1:0]   wrSel;
    logic [HALF_W-1:0] half;
    logic [REG_W-1:0]  wrData;
    logic              rdHit;
    logic [SEL_W-1:0]  rdSel;
  } busStrobe_t;
endpackage

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output busStrobe_t        strb
);
  logic [SEL_W-1:0] regIdx;
  logic             inMap;

  assign regIdx = regAddr[ADDR_W-1:HALF_W];
  assign inMap  = regIdx < SEL_W'(NREG);

  always_comb begin
    strb.wrSel  = (regWrEn && inMap) ? (NREG'(1) << regIdx) : '0;
    strb.half   = regAddr[HALF_W-1:0];
    strb.wrData = regWrData;
    strb.rdHit  = inMap;
    strb.rdSel  = regIdx;
  end
endmodule

// File: rtl/mbx_irq_dp.sv
module mbx_irq_dp
  import mbx_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  busStrobe_t           strb,
  input  logic [MBX_COUNT-1:0] evRxData,
  input  logic [MBX_COUNT-1:0] evRxRemote,
  input  logic [MBX_COUNT-1:0] evOverwrite,
  input  logic [MBX_COUNT-1:0] evTxDone,
  input  logic [MBX_COUNT-1:0] evTxAbort,
  output logic [REG_W-1:0]     rdData,
  output logic                 irqRxData,
  output logic                 irqRemote,
  output logic                 irqOverrun,
  output logic                 irqEmpty
);
  logic [MBX_COUNT-1:0] regView [NREG];
  logic [MBX_COUNT-1:0] setEv   [NFLAG];
  logic [MBX_COUNT-1:0] wrVec, halfMask, txClose, rdWord, rdShift;
  logic [MBX_COUNT-1:0] rxEn, txEn;

  assign setEv[IDX_RX]    = evRxData;
  assign setEv[IDX_RMT]   = evRxRemote;
  assign setEv[IDX_OVR]   = evOverwrite;
  assign setEv[IDX_TXACK] = evTxDone;
  assign setEv[IDX_ABACK] = evTxAbort;

  assign wrVec    = {{(MBX_COUNT-REG_W){1'b0}}, strb.wrData} << (REG_W * strb.half);
  assign halfMask = {{(MBX_COUNT-REG_W){1'b0}}, {REG_W{1'b1}}} << (REG_W * strb.half);
  assign txClose  = evTxDone | evTxAbort;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [MBX_COUNT-1:0] q;
    logic [MBX_COUNT-1:0] ones;
    assign ones = strb.wrSel[g] ? wrVec : '0;

    if (g < NFLAG) begin : g_flag
      // event set wins over write-1-to-clear
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~ones) | setEv[g];
      end
    end else if (g == IDX_MASK || g == IDX_DIR) begin : g_cfg
      localparam logic [MBX_COUNT-1:0] RST_V = (g == IDX_MASK) ? '1 : '0;
      logic [MBX_COUNT-1:0] keep;
      assign keep = strb.wrSel[g] ? ~halfMask : '1;
      always_ff @(posedge clk) begin
        if (rst) q <= RST_V;
        else     q <= (q & keep) | ones;
      end
    end else begin : g_req
      // a new request written in the closing cycle survives
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~txClose) | ones;
      end
    end

    assign regView[g] = q;
  end

  always_comb begin
    rdWord  = strb.rdHit ? regView[strb.rdSel] : '0;
    rdShift = rdWord >> (REG_W * strb.half);
    rdData  = rdShift[REG_W-1:0];
  end

  assign rxEn = ~regView[IDX_MASK] & ~regView[IDX_DIR];
  assign txEn = ~regView[IDX_MASK] &  regView[IDX_DIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      irqRxData  <= 1'b0;
      irqRemote  <= 1'b0;
      irqOverrun <= 1'b0;
      irqEmpty   <= 1'b0;
    end else begin
      irqRxData  <= |(regView[IDX_RX]  & rxEn);
      irqRemote  <= |(regView[IDX_RMT] & rxEn);
      irqOverrun <= |(regView[IDX_OVR] & rxEn);
      irqEmpty   <= |((regView[IDX_TXACK] | regView[IDX_ABACK]) & txEn);
    end
  end

  // R2 / R4: a data-received event always leaves its flag set
  p_event_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (|evRxData) |=> ((regView[IDX_RX] & $past(evRxData)) == $past(evRxData)));

  // R9: a finish clears pending unless a new request is written alongside
  p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
    ((|evTxDone) && !strb.wrSel[IDX_TXPEND]) |=>
      ((regView[IDX_TXPEND] & $past(evTxDone)) == '0));

  // R9: acknowledge is set regardless of mask
  p_ack_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (|evTxAbort) |=> ((regView[IDX_ABACK] & $past(evTxAbort)) == $past(evTxAbort)));

  // R8: with every mailbox masked no request line rises
  p_all_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (&regView[IDX_MASK]) |=> !(irqRxData || irqRemote || irqOverrun || irqEmpty));

  // R10: unused addresses read zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !strb.rdHit |-> (rdData == '0));
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
  import mbx_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [MBX_COUNT-1:0] evRxData,
  input  logic [MBX_COUNT-1:0] evRxRemote,
  input  logic [MBX_COUNT-1:0] evOverwrite,
  input  logic [MBX_COUNT-1:0] evTxDone,
  input  logic [MBX_COUNT-1:0] evTxAbort,
  output logic                 irqRxData,
  output logic                 irqRemote,
  output logic                 irqOverrun,
  output logic                 irqEmpty
);
  busStrobe_t strb;

  mbx_irq_ctrl i_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  mbx_irq_dp i_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .evRxData    (evRxData),
    .evRxRemote  (evRxRemote),
    .evOverwrite (evOverwrite),
    .evTxDone    (evTxDone),
    .evTxAbort   (evTxAbort),
    .rdData      (regRdData),
    .irqRxData   (irqRxData),
    .irqRemote   (irqRemote),
    .irqOverrun  (irqOverrun),
    .irqEmpty    (irqEmpty)
  );
endmodule

// File: tb/test_mbx_irq_unit.sv
module test_mbx_irq_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [31:0] evRxData = '0, evRxRemote = '0, evOverwrite = '0, evTxDone = '0, evTxAbort = '0;
  logic        irqRxData, irqRemote, irqOverrun, irqEmpty;

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbx_irq_unit i_mbx_irq_unit (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .evRxData(evRxData), .evRxRemote(evRxRemote),
    .evOverwrite(evOverwrite), .evTxDone(evTxDone), .evTxAbort(evTxAbort),
    .irqRxData(irqRxData), .irqRemote(irqRemote), .irqOverrun(irqOverrun), .irqEmpty(irqEmpty)
  );

  // behavioural model: m[0..8] follow the register index table
  bit [31:0] m [9];
  bit        mIrq [4];

  function automatic bit [15:0] modelRead(input bit [4:0] a);
    if (a >= 18) return 16'h0;
    return 16'(m[a/2] >> (16 * (a % 2)));
  endfunction

  always @(posedge clk) begin
    bit [31:0] ones [9];
    bit [31:0] keep [9];
    for (int i = 0; i < 9; i++) begin ones[i] = 0; keep[i] = '1; end
    if (regWrEn && regAddr < 18) begin
      ones[regAddr/2] = {16'h0, regWrData} << (16 * (regAddr % 2));
      keep[regAddr/2] = ~({16'h0, 16'hFFFF} << (16 * (regAddr % 2)));
    end
    if (rst) begin
      for (int i = 0; i < 9; i++) m[i] <= 0;
      m[5] <= '1;
      for (int i = 0; i < 4; i++) mIrq[i] <= 0;
    end else begin
      mIrq[0] <= |(m[0] & ~m[5] & ~m[6]);
      mIrq[1] <= |(m[1] & ~m[5] & ~m[6]);
      mIrq[2] <= |(m[2] & ~m[5] & ~m[6]);
      mIrq[3] <= |((m[3] | m[4]) & ~m[5] & m[6]);
      m[0] <= (m[0] & ~ones[0]) | evRxData;
      m[1] <= (m[1] & ~ones[1]) | evRxRemote;
      m[2] <= (m[2] & ~ones[2]) | evOverwrite;
      m[3] <= (m[3] & ~ones[3]) | evTxDone;
      m[4] <= (m[4] & ~ones[4]) | evTxAbort;
      m[5] <= (m[5] & keep[5]) | ones[5];
      m[6] <= (m[6] & keep[6]) | ones[6];
      m[7] <= (m[7] & ~(evTxDone | evTxAbort)) | ones[7];
      m[8] <= (m[8] & ~(evTxDone | evTxAbort)) | ones[8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, 1 ns before the rising edge
  always @(negedge clk) begin
    #4;
    if (running) begin
      chk("R6 irqRxData model",  {31'b0, irqRxData},  {31'b0, mIrq[0]});
      chk("R6 irqRemote model",  {31'b0, irqRemote},  {31'b0, mIrq[1]});
      chk("R6 irqOverrun model", {31'b0, irqOverrun}, {31'b0, mIrq[2]});
      chk("R7 irqEmpty model",   {31'b0, irqEmpty},   {31'b0, mIrq[3]});
      chk("R2 read model",       {16'b0, regRdData},  {16'b0, modelRead(regAddr)});
    end
  end

  task automatic rdChk(input bit [4:0] a, input bit [15:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(tag, {16'b0, regRdData}, {16'b0, exp});
    @(negedge clk);
  endtask

  task automatic wr(input bit [4:0] a, input bit [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic clearEv();
    evRxData = '0; evRxRemote = '0; evOverwrite = '0; evTxDone = '0; evTxAbort = '0;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    running = 1;
    // R1: reset state
    chk("R1 irq lines", {28'b0, irqRxData, irqRemote, irqOverrun, irqEmpty}, 32'h0);
    for (int a = 0; a < 18; a++)
      rdChk(5'(a), (a == 10 || a == 11) ? 16'hFFFF : 16'h0000, "R1 reset read");

    // R2 / R8: events on masked mailboxes
    evRxData = (32'h1 << 3) | (32'h1 << 20); evRxRemote = 32'h1 << 7;
    @(negedge clk); clearEv();
    rdChk(0, 16'h0008, "R2 rx low half");
    rdChk(1, 16'h0010, "R2 rx high half");
    rdChk(2, 16'h0080, "R2 remote flag");
    chk("R8 masked no irq", {31'b0, irqRxData}, 32'h0);

    // R6 / R5: unmask mailbox 3
    wr(10, 16'hFFF7);
    @(negedge clk);
    chk("R6 unmask raises irqRxData", {31'b0, irqRxData}, 32'h1);
    chk("R6 masked remote stays low", {31'b0, irqRemote}, 32'h0);
    rdChk(10, 16'hFFF7, "R5 mask readback");
    rdChk(11, 16'hFFFF, "R5 other half untouched");

    // R8: remask drops line, flag kept
    wr(10, 16'hFFFF);
    @(negedge clk);
    chk("R8 remask drops irq", {31'b0, irqRxData}, 32'h0);
    rdChk(0, 16'h0008, "R8 flag kept");

    // R3: write 0 no effect, write 1 clears
    wr(0, 16'h0000);
    rdChk(0, 16'h0008, "R3 write0 no effect");
    wr(0, 16'h0008);
    rdChk(0, 16'h0000, "R3 write1 clears");

    // R4: set wins over clear
    regWrEn = 1'b1; regAddr = 0; regWrData = 16'h0020; evRxData = 32'h1 << 5;
    @(negedge clk); regWrEn = 1'b0; clearEv();
    rdChk(0, 16'h0020, "R4 set wins");

    // R9 / R7: transmit on mailbox 0
    wr(12, 16'h0001);
    wr(14, 16'h0001);
    wr(16, 16'h0001);
    rdChk(14, 16'h0001, "R9 pending set");
    rdChk(12, 16'h0001, "R5 dir readback");
    wr(10, 16'hFFFE);
    evTxDone = 32'h1;
    @(negedge clk); clearEv();
    rdChk(14, 16'h0000, "R9 pending cleared");
    rdChk(16, 16'h0000, "R9 cancel cleared");
    rdChk(6, 16'h0001, "R9 txack set");
    chk("R7 empty irq", {31'b0, irqEmpty}, 32'h1);
    wr(6, 16'h0001);
    @(negedge clk);
    chk("R7 empty irq drops", {31'b0, irqEmpty}, 32'h0);

    // R9 / R8: masked abort on mailbox 16
    wr(13, 16'h0001);
    wr(15, 16'h0001);
    evTxAbort = 32'h1 << 16;
    @(negedge clk); clearEv();
    rdChk(15, 16'h0000, "R9 abort clears pending");
    rdChk(9, 16'h0001, "R9 abort ack set");
    chk("R8 masked abort no irq", {31'b0, irqEmpty}, 32'h0);

    // R9: new request written alongside finish survives
    regWrEn = 1'b1; regAddr = 14; regWrData = 16'h0001; evTxDone = 32'h1;
    @(negedge clk); regWrEn = 1'b0; clearEv();
    rdChk(14, 16'h0001, "R9 write-set wins");
    wr(6, 16'h0001);

    // R11: rx event on transmit mailbox 0 (unmasked)
    evRxData = 32'h1;
    @(negedge clk); clearEv();
    @(negedge clk);
    chk("R11 no rx irq on tx mailbox", {31'b0, irqRxData}, 32'h0);
    rdChk(0, 16'h0021, "R11 flag still set");
    // tx-type flag on receive mailbox 5 (unmasked)
    wr(10, 16'hFFDE);
    evTxAbort = 32'h1 << 5;
    @(negedge clk); clearEv();
    @(negedge clk);
    chk("R11 no empty irq on rx mailbox", {31'b0, irqEmpty}, 32'h0);
    chk("R6 rx irq from mailbox 5", {31'b0, irqRxData}, 32'h1);

    // R10: unused addresses
    wr(20, 16'hABCD);
    rdChk(20, 16'h0000, "R10 unused read");
    rdChk(31, 16'h0000, "R10 top address");

    // random phase compared against the model each cycle
    for (int i = 0; i < 600; i++) begin
      regWrEn     = ($urandom % 3) == 0;
      regAddr     = 5'($urandom % 24);
      regWrData   = 16'($urandom);
      evRxData    = $urandom & $urandom & $urandom;
      evRxRemote  = $urandom & $urandom & $urandom;
      evOverwrite = $urandom & $urandom & $urandom;
      evTxDone    = $urandom & $urandom & $urandom;
      evTxAbort   = $urandom & $urandom & $urandom;
      @(negedge clk);
    end
    regWrEn = 1'b0; clearEv();
    @(negedge clk);
    @(negedge clk);
    running = 0;
    summary();
  end
endmodule